// File: doc/BRIEF.md
# T1 Per-Timeslot Payload Conditioner

This block conditions the transmit payload of a 24-channel T1/J1 frame, one 8-bit timeslot per valid cycle. Each channel owns an 8-bit control word that selects three independent treatments: replacing the payload byte, inverting selected bits, and suppressing output bit clocks. The input is a frame-aligned byte stream tagged with its channel index. The result is a conditioned byte and an 8-bit clock-enable mask, both registered with one cycle of latency and tagged with a matching valid strobe and channel index.

Replacement can insert a programmable trunk code, a digital milliwatt tone byte in A-law or µ-law coding, or a loopback byte taken from the receive path. A global selector can force one replacement source onto every channel at once. Bit inversion is applied after replacement. Within a channel, bits are numbered 1 to 8 with bit 1 as the MSB. On the ports, bit 1 is carried on index 7 and bit 8 on index 0, for both the byte and the mask.

Top module: `t1c_top`

## Requirements
- R1: After reset, every control word is 0 and no output is valid. A slot sent with these defaults leaves the block unchanged with mask 8'hFF.
- R2: A slot presented with `inValid` high appears one clock later with `outValid` high and `outChan` equal to its channel index. A cycle with `inValid` low gives `outValid` low one clock later.
- R3: The control word layout is: bits 7..5 replacement code, bit 4 sign invert, bit 3 odd invert, bit 2 even invert, bit 1 bit-8 gap, bit 0 whole-channel gap. A word is written through `cfgWrEn`, `cfgWrAddr` and `cfgWrData`. The replacement codes are: 3'b001 for the trunk code, 3'b010 for A-law milliwatt, 3'b011 for µ-law milliwatt, and 3'b100 for the loopback byte.
- R4: Replacement codes 3'b101, 3'b110 and 3'b111 behave like 3'b000: the input byte passes through.
- R5: When `globalSubst` is nonzero, its value is used as the replacement code for every channel in place of the per-channel code.
- R6: The A-law tone cycles through 34 21 21 34 B4 A1 A1 B4. The µ-law tone cycles through 1E 0B 0B 1E 9E 8B 8B 9E. Both start at the first entry after reset and advance by one entry after each slot of the last channel (index 23).
- R7: The sign flag inverts bit 1 (mask 8'h80). The odd flag inverts bits 3, 5 and 7 (mask 8'h2A). The even flag inverts bits 2, 4, 6 and 8 (mask 8'h55). The flags combine by XOR, so with all three set every bit is inverted.
- R8: Inversion is applied to the byte after replacement.
- R9: When gating is allowed, the bit-8 gap flag alone gives mask 8'hFE. The whole-channel gap flag gives mask 8'h00, whatever the bit-8 gap flag holds.
- R10: Gating is allowed only when both `txClkMaster` and `perChanCtrlEn` are 1. Otherwise the mask is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrAddr | input | 5 | Channel index of the control word to write |
| cfgWrData | input | 8 | Control word to write |
| globalSubst | input | 3 | Global replacement code; 0 selects the per-channel code |
| trunkCode | input | 8 | Programmable trunk code byte |
| loopByte | input | 8 | Loopback byte from the receive path |
| txClkMaster | input | 1 | Transmit clock master mode |
| perChanCtrlEn | input | 1 | Enable for per-channel gap control |
| inValid | input | 1 | Input slot valid |
| inChan | input | 5 | Input slot channel index, 0 to 23 |
| inByte | input | 8 | Input payload byte, index 7 = bit 1 |
| outValid | output | 1 | Output slot valid |
| outChan | output | 5 | Output slot channel index |
| outByte | output | 8 | Conditioned byte |
| outClkEn | output | 8 | Per-bit clock-enable mask, index 7 = bit 1 |

## Verification
The bench builds the block with its default parameters: 24 channels and an 8-entry tone table. With these values, running whole frames back to back walks the milliwatt phase through a full wrap and beyond within a few hundred cycles. Full 24-slot frames also exercise the phase advance on the last channel index, while other channels are checked to hold their own settings over the same frames.

// File: rtl/t1c_pkg.sv
package t1c_pkg;

  localparam int BYTE_W = 8;
  localparam int MW_LEN = 8;
  localparam int MW_W   = $clog2(MW_LEN);

  typedef enum logic [2:0] {
    SUB_NONE  = 3'd0,
    SUB_TRUNK = 3'd1,
    SUB_ALAW  = 3'd2,
    SUB_ULAW  = 3'd3,
    SUB_LOOP  = 3'd4
  } subst_e;

  typedef struct packed {
    logic              valid;
    subst_e            subst;
    logic [BYTE_W-1:0] invMask;
    logic              gapLsb;
    logic              gapAll;
    logic [MW_W-1:0]   mwPhase;
  } strobes_t;

  function automatic subst_e decodeSubst(input logic [2:0] code);
    case (code)
      3'd1:    return SUB_TRUNK;
      3'd2:    return SUB_ALAW;
      3'd3:    return SUB_ULAW;
      3'd4:    return SUB_LOOP;
      default: return SUB_NONE;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] alawTone(input logic [MW_W-1:0] ph);
    logic [BYTE_W-1:0] b;
    b = (ph[0] ^ ph[1]) ? 8'h21 : 8'h34;
    if (ph[2]) b = b | 8'h80;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] ulawTone(input logic [MW_W-1:0] ph);
    logic [BYTE_W-1:0] b;
    b = (ph[0] ^ ph[1]) ? 8'h0B : 8'h1E;
    if (ph[2]) b = b | 8'h80;
    return b;
  endfunction

endpackage

// File: rtl/t1c_ctrl.sv
module t1c_ctrl
  import t1c_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CH_W-1:0]   cfgWrAddr,
  input  logic [BYTE_W-1:0] cfgWrData,
  input  logic [2:0]        globalSubst,
  input  logic              txClkMaster,
  input  logic              perChanCtrlEn,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inChan,
  output strobes_t          strobes
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [BYTE_W-1:0] ctrlMem [NUM_CH];
  logic [BYTE_W-1:0] word;
  logic [MW_W-1:0]   mwPhase;
  logic              gapEn;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ctrlMem[gi] <= '0;
        else if (cfgWrEn && cfgWrAddr == CH_W'(gi)) ctrlMem[gi] <= cfgWrData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mwPhase <= '0;
    else if (inValid && inChan == LAST_CH) mwPhase <= mwPhase + 1'b1;
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (inChan == CH_W'(i)) word = ctrlMem[i];
  end

  assign gapEn = txClkMaster & perChanCtrlEn;

  always_comb begin
    strobes.valid   = inValid;
    strobes.subst   = decodeSubst((globalSubst != 3'd0) ? globalSubst : word[7:5]);
    strobes.invMask = ({8{word[4]}} & 8'h80) ^ ({8{word[3]}} & 8'h2A)
                    ^ ({8{word[2]}} & 8'h55);
    strobes.gapAll  = gapEn & word[0];
    strobes.gapLsb  = gapEn & word[1] & ~word[0];
    strobes.mwPhase = mwPhase;
  end

endmodule

// File: rtl/t1c_datapath.sv
module t1c_datapath
  import t1c_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [CH_W-1:0]   inChan,
  input  logic [BYTE_W-1:0] inByte,
  input  logic [BYTE_W-1:0] trunkCode,
  input  logic [BYTE_W-1:0] loopByte,
  output logic              outValid,
  output logic [CH_W-1:0]   outChan,
  output logic [BYTE_W-1:0] outByte,
  output logic [BYTE_W-1:0] outClkEn
);

  logic [BYTE_W-1:0] substByte;
  logic [BYTE_W-1:0] condByte;
  logic [BYTE_W-1:0] maskNext;

  always_comb begin
    case (strobes.subst)
      SUB_TRUNK: substByte = trunkCode;
      SUB_ALAW:  substByte = alawTone(strobes.mwPhase);
      SUB_ULAW:  substByte = ulawTone(strobes.mwPhase);
      SUB_LOOP:  substByte = loopByte;
      default:   substByte = inByte;
    endcase
    condByte = substByte ^ strobes.invMask;
    if (!strobes.valid)     maskNext = '1;
    else if (strobes.gapAll) maskNext = '0;
    else if (strobes.gapLsb) maskNext = 8'hFE;
    else                     maskNext = '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outChan  <= '0;
      outByte  <= '0;
      outClkEn <= '1;
    end else begin
      outValid <= strobes.valid;
      outClkEn <= maskNext;
      if (strobes.valid) begin
        outChan <= inChan;
        outByte <= condByte;
      end
    end
  end

endmodule

// File: rtl/t1c_top.sv
module t1c_top
  import t1c_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CH_W-1:0]   cfgWrAddr,
  input  logic [7:0]        cfgWrData,
  input  logic [2:0]        globalSubst,
  input  logic [7:0]        trunkCode,
  input  logic [7:0]        loopByte,
  input  logic              txClkMaster,
  input  logic              perChanCtrlEn,
  input  logic              inValid,
  input  logic [CH_W-1:0]   inChan,
  input  logic [7:0]        inByte,
  output logic              outValid,
  output logic [CH_W-1:0]   outChan,
  output logic [7:0]        outByte,
  output logic [7:0]        outClkEn
);

  strobes_t strobes;

  t1c_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .globalSubst(globalSubst), .txClkMaster(txClkMaster),
    .perChanCtrlEn(perChanCtrlEn), .inValid(inValid), .inChan(inChan),
    .strobes(strobes)
  );

  t1c_datapath #(.CH_W(CH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inChan(inChan), .inByte(inByte),
    .trunkCode(trunkCode), .loopByte(loopByte), .outValid(outValid),
    .outChan(outChan), .outByte(outByte), .outClkEn(outClkEn)
  );

endmodule

// File: rtl/t1c_checker.sv
module t1c_checker #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [CH_W-1:0] inChan,
  input logic            txClkMaster,
  input logic            perChanCtrlEn,
  input logic            outValid,
  input logic [CH_W-1:0] outChan,
  input logic [7:0]      outClkEn
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_CHAN_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outChan == $past(inChan)); // R2
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outClkEn == 8'hFF || outClkEn == 8'hFE || outClkEn == 8'h00)); // R9
  AST_UNGATED_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !(txClkMaster && perChanCtrlEn) |=> outClkEn == 8'hFF); // R10

endmodule

bind t1c_top t1c_checker #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inChan(inChan),
  .txClkMaster(txClkMaster), .perChanCtrlEn(perChanCtrlEn),
  .outValid(outValid), .outChan(outChan), .outClkEn(outClkEn)
);

// File: tb/sim_t1c_top.sv
module sim_t1c_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [4:0] cfgWrAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic [2:0] globalSubst = '0;
  logic [7:0] trunkCode = 8'hD5;
  logic [7:0] loopByte = 8'h6E;
  logic       txClkMaster = 1'b0;
  logic       perChanCtrlEn = 1'b0;
  logic       inValid = 1'b0;
  logic [4:0] inChan = '0;
  logic [7:0] inByte = '0;
  logic       outValid;
  logic [4:0] outChan;
  logic [7:0] outByte;
  logic [7:0] outClkEn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] aTab [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
  logic [7:0] uTab [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};

  always #(CLK_PERIOD / 2) clk = ~clk;

  t1c_top u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .globalSubst(globalSubst), .trunkCode(trunkCode),
    .loopByte(loopByte), .txClkMaster(txClkMaster), .perChanCtrlEn(perChanCtrlEn),
    .inValid(inValid), .inChan(inChan), .inByte(inByte), .outValid(outValid),
    .outChan(outChan), .outByte(outByte), .outClkEn(outClkEn)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeCtrl(input int ch, input logic [7:0] w);
    @(negedge clk);
    inValid = 1'b0;
    cfgWrEn = 1'b1;
    cfgWrAddr = 5'(ch);
    cfgWrData = w;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendSlot(input int ch, input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inChan = 5'(ch);
    inByte = b;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    doReset();
    #1;
    check("R1 outValid after reset", {7'd0, outValid}, 8'h00);
    check("R1 mask after reset", outClkEn, 8'hFF);
    txClkMaster = 1'b1; perChanCtrlEn = 1'b1;
    sendSlot(2, 8'hC3);
    check("R1 default passthrough", outByte, 8'hC3);
    check("R1 default mask", outClkEn, 8'hFF);
    idle();
  endtask

  task automatic testLatency();
    sendSlot(17, 8'h11);
    check("R2 valid", {7'd0, outValid}, 8'h01);
    check("R2 chan", {3'd0, outChan}, 8'd17);
    sendSlot(9, 8'h22);
    check("R2 chan back-to-back", {3'd0, outChan}, 8'd9);
    idle();
    check("R2 idle valid", {7'd0, outValid}, 8'h00);
  endtask

  task automatic testPerChannel();
    writeCtrl(3, 8'h20);
    writeCtrl(4, 8'h80);
    sendSlot(3, 8'h00);
    check("R3 trunk code", outByte, 8'hD5);
    sendSlot(4, 8'h00);
    check("R3 loopback", outByte, 8'h6E);
    sendSlot(5, 8'h99);
    check("R3 unwritten channel passthrough", outByte, 8'h99);
    idle();
  endtask

  task automatic testReserved();
    writeCtrl(5, 8'hA0);
    writeCtrl(6, 8'hE0);
    sendSlot(5, 8'h47);
    check("R4 code 101 passthrough", outByte, 8'h47);
    sendSlot(6, 8'h48);
    check("R4 code 111 passthrough", outByte, 8'h48);
    idle();
  endtask

  task automatic testGlobal();
    globalSubst = 3'd1;
    sendSlot(4, 8'h00);
    check("R5 global trunk over loopback channel", outByte, 8'hD5);
    sendSlot(12, 8'h00);
    check("R5 global trunk on plain channel", outByte, 8'hD5);
    globalSubst = 3'd4;
    sendSlot(3, 8'h00);
    check("R5 global loopback over trunk channel", outByte, 8'h6E);
    globalSubst = 3'd0;
    sendSlot(3, 8'h00);
    check("R5 back to per-channel", outByte, 8'hD5);
    idle();
  endtask

  task automatic testTone();
    doReset();
    writeCtrl(0, 8'h40);
    writeCtrl(1, 8'h60);
    writeCtrl(23, 8'h60);
    for (int f = 0; f < 10; f++) begin
      for (int ch = 0; ch < 24; ch++) begin
        sendSlot(ch, 8'h5A);
        if (ch == 0) check($sformatf("R6 A-law frame %0d", f), outByte, aTab[f % 8]);
        if (ch == 1) check($sformatf("R6 mu-law frame %0d", f), outByte, uTab[f % 8]);
        if (ch == 23) check($sformatf("R6 mu-law last ch frame %0d", f), outByte, uTab[f % 8]);
      end
    end
    idle();
  endtask

  task automatic testInvert();
    writeCtrl(6, 8'h10);
    writeCtrl(7, 8'h08);
    writeCtrl(8, 8'h04);
    writeCtrl(9, 8'h1C);
    writeCtrl(10, 8'h18);
    sendSlot(6, 8'h00);  check("R7 sign", outByte, 8'h80);
    sendSlot(7, 8'h00);  check("R7 odd", outByte, 8'h2A);
    sendSlot(8, 8'h00);  check("R7 even", outByte, 8'h55);
    sendSlot(9, 8'hA5);  check("R7 all three", outByte, 8'h5A);
    sendSlot(10, 8'hFF); check("R7 sign+odd", outByte, 8'h55);
    idle();
  endtask

  task automatic testOrder();
    trunkCode = 8'h3C;
    writeCtrl(11, 8'h24);
    sendSlot(11, 8'h00);
    check("R8 trunk then even invert", outByte, 8'h69);
    writeCtrl(12, 8'h90);
    sendSlot(12, 8'h00);
    check("R8 loopback then sign invert", outByte, 8'hEE);
    idle();
  endtask

  task automatic testGap();
    txClkMaster = 1'b1; perChanCtrlEn = 1'b1;
    writeCtrl(13, 8'h02);
    writeCtrl(14, 8'h01);
    writeCtrl(15, 8'h03);
    sendSlot(13, 8'h00); check("R9 bit8 gap", outClkEn, 8'hFE);
    sendSlot(14, 8'h00); check("R9 whole gap", outClkEn, 8'h00);
    sendSlot(15, 8'h00); check("R9 both flags", outClkEn, 8'h00);
    sendSlot(16, 8'h00); check("R9 no gap", outClkEn, 8'hFF);
    perChanCtrlEn = 1'b0;
    sendSlot(14, 8'h00); check("R10 enable low", outClkEn, 8'hFF);
    perChanCtrlEn = 1'b1; txClkMaster = 1'b0;
    sendSlot(13, 8'h00); check("R10 not master", outClkEn, 8'hFF);
    txClkMaster = 1'b1;
    sendSlot(13, 8'h00); check("R10 gating restored", outClkEn, 8'hFE);
    idle();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testLatency();
    testPerChannel();
    testReserved();
    testGlobal();
    testInvert();
    testOrder();
    testGap();
    testTone();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired got=running exp=finished");
    finishRun();
  end

endmodule